// File: doc/BRIEF.md
# Four-Lane Configurable Serial Audio Transmitter

This block takes frames of eight parallel audio samples and sends them out as four stereo serial data lanes. All four lanes move in lockstep on one shared set of clocks: a master clock, a bit clock and a word-select clock. Every frame holds 64 bit-clock periods, with 32 periods per channel slot. Each slot carries one 24-bit sample, and any slot bit that does not hold sample data is sent as zero.

A frame is accepted through a ready/valid handshake that opens for a single system-clock cycle at each frame boundary. The accepted frame is copied into a shadow register, so the source may change its data while the frame is being sent. Three format choices are made at run time:
- a one-bit delay after the word-select edge, or none;
- left or right placement of the sample within its slot;
- most- or least-significant bit first.

A divider setting sets the bit-clock rate. All of these settings are sampled only at frame boundaries. With a 24.576 MHz master clock and a divider of 4, the block gives a 96 kHz frame rate.

If no frame is ready at a boundary, the block sends a frame of zeros and raises an underrun pulse.

Top module: `i2s_multi_tx`

## Requirements
- R1: `mclk` is the system clock divided by two. It is low in reset and toggles on every system clock edge after reset.
- R2: Each bit-clock half period lasts max(`cfg_div`, 2) system clock cycles, so a divider value below 2 acts as 2. From reset until the first frame boundary, the half period is 2 cycles.
- R3: A frame is 64 bit-clock periods. `ws` is low for positions 0 to 31, which form the left slot, and high for positions 32 to 63, which form the right slot. `ws` and `sd` change only right after a falling bit-clock edge, so they are stable at the rising edge.
- R4: The sample for lane L and channel C (0 = left, 1 = right) is taken from `in_data[(2L+C)*24 +: 24]`. All four lanes are sent at the same time.
- R5: When `cfg_lsb` is 0, each sample is sent most-significant bit first. When it is 1, it is sent least-significant bit first.
- R6: When `cfg_right` is 0, the sample fills slot bits 0 to 23. When it is 1, the sample fills slot bits 8 to 31. Every other slot bit is 0.
- R7: When `cfg_delay` is 1, the whole slot stream arrives one bit-clock later. Frame position 0 then carries the last slot bit of the previous frame's right channel, or 0 if there was no previous frame.
- R8: `in_ready` is high for exactly one system clock cycle at each frame boundary. A frame is captured only when `in_valid` is high in that cycle. Changes to `in_data` at any other time do not affect the output.
- R9: If `in_valid` is low at a frame boundary, the whole next frame is sent as zeros on every lane, and `underrun` is high for exactly one system clock cycle.
- R10: Changes to `cfg_delay`, `cfg_right`, `cfg_lsb` and `cfg_div` take effect only from the next frame boundary.
- R11: During reset, `bclk`, `mclk`, `sd`, `underrun` and `in_ready` are all 0, and `ws` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_div | input | 8 | Bit-clock half period in system clocks (minimum 2) |
| cfg_delay | input | 1 | 1: one-bit delay after the word-select edge |
| cfg_right | input | 1 | 1: sample placed at the end of its slot |
| cfg_lsb | input | 1 | 1: least-significant bit first |
| in_valid | input | 1 | A frame is offered on `in_data` |
| in_ready | output | 1 | Frame accepted in this cycle |
| in_data | input | 192 | Eight 24-bit samples, lane-major, left channel first |
| mclk | output | 1 | Master clock |
| bclk | output | 1 | Bit clock |
| ws | output | 1 | Word select (0 = left, 1 = right) |
| sd | output | 4 | Serial data, one bit per lane |
| underrun | output | 1 | One-cycle pulse when a frame of zeros is sent |

## Verification
The assertions check these properties on every cycle:
- the master clock toggles on each edge;
- no bit-clock phase is shorter than two cycles;
- `ws` moves only at slot boundaries;
- `sd` moves only after a falling bit-clock edge;
- the handshake and underrun pulses last one cycle;
- padding bits stay zero.

Only the bench scenarios can show that each transmitted bit is the correct bit of the correct sample. The bench rebuilds every slot arithmetically for all eight format choices and three divider values, including the delayed carry bit, a format change made mid-frame, underrun frames and the divider floor.

// File: rtl/i2s_tx_pkg.sv
package i2s_tx_pkg;

  typedef struct packed {
    logic delay;
    logic right;
    logic lsb;
  } fmt_t;

  // Returns the wire value of slot bit e for one sample.
  function automatic logic slot_bit(input logic [63:0] smp, input int e,
                                    input int sw, input int slw,
                                    input logic right, input logic lsb);
    int j;
    j = right ? e - (slw - sw) : e;
    if (j < 0 || j >= sw) return 1'b0;
    return lsb ? smp[6'(j)] : smp[6'(sw - 1 - j)];
  endfunction

endpackage

// File: rtl/i2s_clkgen.sv
module i2s_clkgen #(
  parameter int DIV_W  = 8,
  parameter int SLOT_W = 32,
  localparam int FRAME_BITS = 2 * SLOT_W,
  localparam int POS_W = $clog2(FRAME_BITS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_act,
  output logic             mclk,
  output logic             bclk,
  output logic             fall_tick,
  output logic             frame_tick,
  output logic [POS_W-1:0] pos
);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(FRAME_BITS - 1);

  logic [DIV_W-1:0] half;
  logic [DIV_W-1:0] cnt;
  logic             phase_end;

  assign half       = (div_act < DIV_W'(2)) ? DIV_W'(2) : div_act;
  assign phase_end  = (cnt == half - DIV_W'(1));
  assign fall_tick  = phase_end && bclk;
  assign frame_tick = fall_tick && (pos == LAST_POS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mclk <= 1'b0;
      bclk <= 1'b0;
      cnt  <= '0;
      pos  <= LAST_POS;
    end else begin
      mclk <= ~mclk;
      if (phase_end) begin
        cnt  <= '0;
        bclk <= ~bclk;
        if (bclk) pos <= pos + POS_W'(1);
      end else begin
        cnt <= cnt + DIV_W'(1);
      end
    end
  end

  a_r1_mclk_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (mclk != $past(mclk)));
  a_r2_bclk_min_phase: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(bclk) |=> $stable(bclk));
  a_r3_pos_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pos) |-> ($past(fall_tick) && !bclk));

endmodule

// File: rtl/i2s_frame_buf.sv
module i2s_frame_buf
  import i2s_tx_pkg::*;
#(
  parameter int LANES    = 4,
  parameter int SAMPLE_W = 24,
  parameter int DIV_W    = 8,
  localparam int DATA_W  = 2 * LANES * SAMPLE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_tick,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  fmt_t              fmt_in,
  input  logic [DIV_W-1:0]  div_in,
  output logic              in_ready,
  output logic [DATA_W-1:0] shadow,
  output fmt_t              fmt_act,
  output logic [DIV_W-1:0]  div_act,
  output logic              underrun
);
  logic take;

  assign in_ready = frame_tick;
  assign take     = frame_tick && in_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow   <= '0;
      fmt_act  <= '0;
      div_act  <= DIV_W'(2);
      underrun <= 1'b0;
    end else begin
      underrun <= frame_tick && !in_valid;
      if (frame_tick) begin
        shadow  <= take ? in_data : '0;
        fmt_act <= fmt_in;
        div_act <= div_in;
      end
    end
  end

  a_r8_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> !in_ready);
  a_r8_shadow_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(frame_tick) |-> $stable(shadow));
  a_r9_underrun_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |-> !$past(underrun));
  a_r10_cfg_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(frame_tick) |-> ($stable(fmt_act) && $stable(div_act)));

endmodule

// File: rtl/i2s_lane_ser.sv
module i2s_lane_ser
  import i2s_tx_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int SLOT_W   = 32,
  localparam int POS_W   = $clog2(2 * SLOT_W)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_tick,
  input  logic [POS_W-1:0]    pos,
  input  logic [SAMPLE_W-1:0] left_smp,
  input  logic [SAMPLE_W-1:0] right_smp,
  input  fmt_t                fmt,
  output logic                sd
);
  logic             carry;
  logic [POS_W-1:0] spos;
  logic             ch;
  logic [POS_W-2:0] e;
  logic             pad_zone;

  assign spos = pos - POS_W'(fmt.delay);
  assign ch   = spos[POS_W-1];
  assign e    = spos[POS_W-2:0];
  assign pad_zone = !fmt.delay && !fmt.right && (pos[POS_W-2:0] >= (POS_W-1)'(SAMPLE_W));

  // Last slot bit of the outgoing frame, kept for the delayed first position.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) carry <= 1'b0;
    else if (frame_tick)
      carry <= slot_bit(64'(right_smp), SLOT_W - 1, SAMPLE_W, SLOT_W, fmt.right, fmt.lsb);
  end

  always_comb begin
    if (fmt.delay && pos == '0)
      sd = carry;
    else
      sd = slot_bit(ch ? 64'(right_smp) : 64'(left_smp), int'(e), SAMPLE_W, SLOT_W,
                    fmt.right, fmt.lsb);
  end

  a_r6_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
    pad_zone |-> !sd);

endmodule

// File: rtl/i2s_multi_tx.sv
module i2s_multi_tx
  import i2s_tx_pkg::*;
#(
  parameter int LANES    = 4,
  parameter int SAMPLE_W = 24,
  parameter int SLOT_W   = 32,
  parameter int DIV_W    = 8,
  localparam int DATA_W  = 2 * LANES * SAMPLE_W,
  localparam int POS_W   = $clog2(2 * SLOT_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              cfg_delay,
  input  logic              cfg_right,
  input  logic              cfg_lsb,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              mclk,
  output logic              bclk,
  output logic              ws,
  output logic [LANES-1:0]  sd,
  output logic              underrun
);
  logic              fall_tick;
  logic              frame_tick;
  logic [POS_W-1:0]  pos;
  logic [DATA_W-1:0] shadow;
  fmt_t              fmt_in;
  fmt_t              fmt_act;
  logic [DIV_W-1:0]  div_act;

  assign fmt_in = '{delay: cfg_delay, right: cfg_right, lsb: cfg_lsb};
  assign ws     = pos[POS_W-1];

  i2s_clkgen #(.DIV_W(DIV_W), .SLOT_W(SLOT_W)) u_clk (
    .clk(clk), .rst_n(rst_n), .div_act(div_act), .mclk(mclk), .bclk(bclk),
    .fall_tick(fall_tick), .frame_tick(frame_tick), .pos(pos));

  i2s_frame_buf #(.LANES(LANES), .SAMPLE_W(SAMPLE_W), .DIV_W(DIV_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .in_valid(in_valid),
    .in_data(in_data), .fmt_in(fmt_in), .div_in(cfg_div), .in_ready(in_ready),
    .shadow(shadow), .fmt_act(fmt_act), .div_act(div_act), .underrun(underrun));

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    i2s_lane_ser #(.SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W)) u_ser (
      .clk(clk), .rst_n(rst_n), .frame_tick(frame_tick), .pos(pos),
      .left_smp(shadow[(2*l)*SAMPLE_W +: SAMPLE_W]),
      .right_smp(shadow[(2*l+1)*SAMPLE_W +: SAMPLE_W]),
      .fmt(fmt_act), .sd(sd[l]));
  end

  a_r3_ws_slot_edge: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ws) |-> (pos[POS_W-2:0] == '0));
  a_r3_sd_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sd) |-> $past(fall_tick));

endmodule

// File: tb/i2s_multi_tx_tb.sv
`timescale 1ns/1ps
module i2s_multi_tx_tb;
  localparam int NFR = 3;
  localparam int NOBS = 5;

  logic clk = 0;
  logic rst_n = 0;
  logic [7:0] cfg_div = 8'd2;
  logic cfg_delay = 0, cfg_right = 0, cfg_lsb = 0;
  logic in_valid = 0;
  logic in_ready;
  logic [191:0] in_data = '0;
  logic mclk, bclk, ws, underrun;
  logic [3:0] sd;

  int checks = 0, errors = 0;
  int seg = 0, sent = 0, r = 0, cyc = 0, last_rise = 0, ucnt = 0;
  int eff = 2;
  bit mon_on = 0, flip = 0, done = 0;
  bit d0, rj0, lb0;
  logic pbclk = 0, pmclk = 0;

  always #2.5 clk = ~clk;

  i2s_multi_tx u_dut (.clk(clk), .rst_n(rst_n), .cfg_div(cfg_div), .cfg_delay(cfg_delay),
    .cfg_right(cfg_right), .cfg_lsb(cfg_lsb), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .mclk(mclk), .bclk(bclk), .ws(ws), .sd(sd), .underrun(underrun));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s seg %0d rise %0d actual %0d expected %0d", tag, seg, r, act, exp);
    end
  endtask

  function automatic logic [23:0] gen(input int n, input int i);
    logic [31:0] v;
    v = (n * 8 + i + 1) * 32'h009E3779 ^ (seg * 32'h51ED);
    return v[23:0] ^ {v[7:0], 16'h0};
  endfunction

  function automatic logic [191:0] pack(input int n);
    logic [191:0] p;
    for (int i = 0; i < 8; i++) p[i*24 +: 24] = gen(n, i);
    return p;
  endfunction

  function automatic bit lsb_of(input int n);
    return lb0 ^ (flip && n >= 2);
  endfunction

  function automatic logic slot_of(input int n, input int lane, input int ch, input int e);
    logic [23:0] smp;
    int j;
    if (n < 0 || n >= NFR) return 1'b0;
    smp = gen(n, lane * 2 + ch);
    j = rj0 ? e - 8 : e;
    if (j < 0 || j > 23) return 1'b0;
    return lsb_of(n) ? smp[j] : smp[23 - j];
  endfunction

  function automatic logic exp_bit(input int n, input int lane, input int p);
    int s;
    if (d0 && p == 0) return slot_of(n - 1, lane, 1, 31);
    s = d0 ? p - 1 : p;
    return slot_of(n, lane, s / 32, s % 32);
  endfunction

  // Observer: samples away from the active edge.
  always @(negedge clk) begin
    if (mon_on) begin
      cyc++;
      if (underrun) ucnt++;
      if (cyc > 1 && cyc < 20) chk(mclk != pmclk, "R1 mclk toggle", mclk, !pmclk);
      if (bclk && !pbclk) begin
        if (r == 1) chk(cyc - last_rise == 2 + eff, "R10 R2 first divider", cyc - last_rise, 2 + eff);
        if (r >= 2) chk(cyc - last_rise == 2 * eff, "R2 bclk period", cyc - last_rise, 2 * eff);
        if (r == 0) begin
          chk(ws == 1'b1, "R3 ws pre-frame", ws, 1);
          chk(sd == 4'h0, "R11 sd pre-frame", sd, 0);
        end else begin
          int p, n;
          p = (r - 1) % 64;
          n = (r - 1) / 64;
          chk(ws == (p >= 32), "R3 ws slot", ws, p >= 32);
          for (int l = 0; l < 4; l++) begin
            string tag;
            if (n >= NFR && !(d0 && p == 0)) tag = "R9 zero frame";
            else if (flip && n >= 2) tag = "R10 format change";
            else if (d0 && p == 0) tag = "R7 delay carry";
            else if (exp_bit(n, l, p) == 1'b0) tag = "R6 pad or zero";
            else tag = "R4 R5 sample bit";
            chk(sd[l] == exp_bit(n, l, p), tag, sd[l], exp_bit(n, l, p));
          end
        end
        last_rise = cyc;
        r++;
      end
      pbclk = bclk;
      pmclk = mclk;
    end
  end

  task automatic run_seg(input int dv, input int c);
    rst_n = 0;
    mon_on = 0;
    d0 = c[0]; rj0 = c[1]; lb0 = c[2];
    flip = (c == 5);
    cfg_delay = d0; cfg_right = rj0; cfg_lsb = lb0;
    cfg_div = 8'(dv);
    eff = (dv < 2) ? 2 : dv;
    seg++;
    sent = 0; r = 0; cyc = 0; last_rise = 0; ucnt = 0; pbclk = 0; pmclk = 0;
    in_valid = 1;
    in_data = pack(0);
    repeat (3) @(negedge clk);
    rst_n = 1;
    mon_on = 1;
    fork
      begin
        while (sent < NFR) begin
          @(negedge clk);
          if (in_ready) begin
            @(posedge clk);
            #1;
            sent++;
            if (sent < NFR) in_data = pack(sent);
            else begin
              in_valid = 0;
              in_data = {8{24'hA5C3F1}};
            end
          end
        end
      end
    join_none
    if (flip) begin
      wait (r >= 1 + 64 + 10);
      cfg_lsb = ~cfg_lsb;
    end
    wait (r >= 1 + NOBS * 64);
    @(negedge clk);
    chk(sent == NFR, "R8 frames accepted", sent, NFR);
    chk(ucnt == NOBS - NFR, "R9 underrun pulses", ucnt, NOBS - NFR);
    mon_on = 0;
  endtask

  initial begin
    repeat (2) @(negedge clk);
    chk(bclk == 0 && mclk == 0, "R11 clocks in reset", {bclk, mclk}, 0);
    chk(ws == 1, "R11 ws in reset", ws, 1);
    chk(sd == 0 && underrun == 0 && in_ready == 0, "R11 outputs in reset",
        {sd, underrun, in_ready}, 0);
    for (int dv = 1; dv <= 3; dv++)
      for (int c = 0; c < 8; c++)
        run_seg(dv, c);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule